// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a multithreaded out-of-order core, only one hardware thread can use a given commit slot. This block decides which thread's reorder-buffer head may retire in that slot. Each thread supplies a status code, an empty flag, a head-ready flag and the sequence number of its head entry. An active mask and a static policy input complete the inputs. The block answers combinationally with a valid flag and a thread index. The caller drives `grant_take` in any cycle where it uses the grant.

Two ordering policies are available. The rotating policy keeps an internal priority list of all threads. It grants the first candidate in that list. When a grant is taken, the granted thread moves to the back of the list. The age policy grants the candidate whose head has the smallest sequence number. The aggressive setting behaves the same as the age policy. When exactly one thread is active, the block skips candidate ranking. It grants that thread whenever its status allows commit, and the caller checks head readiness itself.

Top module: `commit_thread_pick`

## Requirements
- R1: `policy_sel` encoding: 0 is aggressive, which behaves the same as age order. 1 is rotating order. 2 is age order. 3 is treated as age order.
- R2: A thread can be granted only while it is active and its status code allows commit. The codes 0 (running), 1 (idle) and 2 (fetch trap pending) allow commit. The codes 3 (squashing), 4 (trap pending) and the codes 5 to 7 do not.
- R3: When two or more threads are active, a thread is a candidate only if it is eligible, `head_ready` is 1 and `rob_empty` is 0.
- R4: Under rotating order, the grant goes to the first candidate found when the priority list is scanned from front to back.
- R5: Under rotating order, a clock edge with `grant_take`=1 and `grant_valid`=1 moves the granted thread to the back of the list. All other threads keep their relative order.
- R6: After reset, the priority list holds threads 0, 1, …, N-1 in that order from the front.
- R7: Under age order, the grant goes to the candidate with the smallest unsigned `head_seq`. If two candidates have the same value, the lower thread index wins.
- R8: When two or more threads are active and there is no candidate, `grant_valid` is 0 and `grant_tid` is 0.
- R9: When exactly one thread is active, the block grants that thread whenever its status is eligible, regardless of `head_ready` and `rob_empty`. If its status is not eligible, `grant_valid` is 0 and `grant_tid` is 0. The priority list does not change in this mode.
- R10: The priority list does not change on a clock edge when no grant is taken, when the policy is not rotating order, or when only one thread is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Policy select (R1 encoding) |
| thread_active | input | N | Active-thread mask |
| thread_status | input | 3*N | Status code per thread; thread i occupies bits [3i+2:3i] |
| rob_empty | input | N | Reorder buffer empty, per thread |
| head_ready | input | N | Head entry ready to commit, per thread |
| head_seq | input | SEQ_W*N | Head sequence number per thread; thread i occupies bits [SEQ_W*i +: SEQ_W] |
| grant_take | input | 1 | Caller uses the current grant in this cycle |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | clog2(N) | Index of the granted thread |

## Verification
The assertions check the following properties on every cycle:
- The granted thread is active and has an eligible status.
- Outside single-thread mode, the granted thread also has a ready, non-empty head.
- Under age order, no other candidate is older than the granted thread.
- The grant stays clear when there is no candidate.
- The priority list is always a permutation of the thread indices.
- The priority list stays still on every edge where no rotation is earned.

Some behaviour only the bench scenarios can show. These are the exact position a thread takes after it is granted, the front-to-back scan of the rotating list, the order after reset, and the single-thread override of head readiness. The bench confirms them against a queue-based model across mixed policies, masks and status codes.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int STW = 3;

  localparam logic [1:0] POL_AGGR   = 2'd0;
  localparam logic [1:0] POL_ROTATE = 2'd1;
  localparam logic [1:0] POL_AGE    = 2'd2;

  typedef enum logic [STW-1:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_FETCHTRAP = 3'd2,
    ST_SQUASH    = 3'd3,
    ST_TRAPWAIT  = 3'd4
  } thr_status_e;

  function automatic logic is_eligible(input logic [STW-1:0] st);
    return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_FETCHTRAP);
  endfunction

  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/ctp_rr_order.sv
module ctp_rr_order #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  input  logic            rotate,
  output logic [N*TW-1:0] order_flat,
  output logic            rr_valid,
  output logic [TW-1:0]   rr_tid
);
  logic [TW-1:0] order_q [N];
  logic [TW-1:0] rr_pos;

  always_comb begin
    rr_valid = 1'b0;
    rr_tid   = '0;
    rr_pos   = '0;
    for (int k = 0; k < N; k++) begin
      if (!rr_valid && cand[order_q[k]]) begin
        rr_valid = 1'b1;
        rr_tid   = order_q[k];
        rr_pos   = TW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) order_q[k] <= TW'(k);
    end else if (rotate && rr_valid) begin
      for (int k = 0; k < N-1; k++) begin
        if (k >= int'(rr_pos)) order_q[k] <= order_q[k+1];
      end
      order_q[N-1] <= rr_tid;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign order_flat[g*TW +: TW] = order_q[g];
  end
endmodule

// File: rtl/ctp_oldest.sv
module ctp_oldest #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  parameter int TW    = $clog2(N)
) (
  input  logic [N-1:0]       cand,
  input  logic [N*SEQ_W-1:0] seq_flat,
  output logic               old_valid,
  output logic [TW-1:0]      old_tid
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    old_valid = 1'b0;
    old_tid   = '0;
    best      = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!old_valid ||
          ctp_pkg::seq_older(32'(seq_flat[i*SEQ_W +: SEQ_W]), 32'(best)))) begin
        old_valid = 1'b1;
        old_tid   = TW'(i);
        best      = seq_flat[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/commit_thread_pick.sv
module commit_thread_pick #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TW   = $clog2(N),
  localparam int STW  = ctp_pkg::STW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         policy_sel,
  input  logic [N-1:0]       thread_active,
  input  logic [N*STW-1:0]   thread_status,
  input  logic [N-1:0]       rob_empty,
  input  logic [N-1:0]       head_ready,
  input  logic [N*SEQ_W-1:0] head_seq,
  input  logic               grant_take,
  output logic               grant_valid,
  output logic [TW-1:0]      grant_tid
);
  logic [N-1:0]    elig;
  logic [N-1:0]    cand;
  logic            single_mode;
  logic [TW-1:0]   single_tid;
  logic            single_ok;
  logic            rr_valid, old_valid;
  logic [TW-1:0]   rr_tid, old_tid;
  logic            rotate;
  logic [N*TW-1:0] order_flat;
  logic            use_rr;

  for (genvar g = 0; g < N; g++) begin : g_cand
    assign elig[g] = thread_active[g] & ctp_pkg::is_eligible(thread_status[g*STW +: STW]);
    assign cand[g] = elig[g] & head_ready[g] & ~rob_empty[g];
  end

  always_comb begin
    single_tid = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (thread_active[i]) single_tid = TW'(i);
    end
  end

  assign single_mode = ($countones(thread_active) == 1);
  assign single_ok   = elig[single_tid];
  assign use_rr      = (policy_sel == ctp_pkg::POL_ROTATE);
  assign rotate      = grant_take & use_rr & ~single_mode;

  ctp_rr_order #(.N(N), .TW(TW)) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand       (cand),
    .rotate     (rotate),
    .order_flat (order_flat),
    .rr_valid   (rr_valid),
    .rr_tid     (rr_tid)
  );

  ctp_oldest #(.N(N), .SEQ_W(SEQ_W), .TW(TW)) u_old (
    .cand      (cand),
    .seq_flat  (head_seq),
    .old_valid (old_valid),
    .old_tid   (old_tid)
  );

  always_comb begin
    if (single_mode) begin
      grant_valid = single_ok;
      grant_tid   = single_ok ? single_tid : '0;
    end else if (use_rr) begin
      grant_valid = rr_valid;
      grant_tid   = rr_tid;
    end else begin
      grant_valid = old_valid;
      grant_tid   = old_tid;
    end
  end
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  parameter int TW    = $clog2(N),
  parameter int STW   = ctp_pkg::STW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         policy_sel,
  input logic [N-1:0]       thread_active,
  input logic [N*STW-1:0]   thread_status,
  input logic [N-1:0]       rob_empty,
  input logic [N-1:0]       head_ready,
  input logic [N*SEQ_W-1:0] head_seq,
  input logic               grant_take,
  input logic               grant_valid,
  input logic [TW-1:0]      grant_tid,
  input logic [N*TW-1:0]    order_flat
);
  logic         multi;
  logic [N-1:0] ok_thr;
  logic         older_exists;
  logic [N-1:0] seen;
  logic         earned;

  assign multi = ($countones(thread_active) > 1);

  always_comb begin
    older_exists = 1'b0;
    seen = '0;
    for (int j = 0; j < N; j++) begin
      ok_thr[j] = thread_active[j] && ctp_pkg::is_eligible(thread_status[j*STW +: STW])
                  && head_ready[j] && !rob_empty[j];
      if (ok_thr[j] && (head_seq[j*SEQ_W +: SEQ_W] < head_seq[grant_tid*SEQ_W +: SEQ_W] ||
          (head_seq[j*SEQ_W +: SEQ_W] == head_seq[grant_tid*SEQ_W +: SEQ_W] && j < int'(grant_tid))))
        older_exists = 1'b1;
      seen[order_flat[j*TW +: TW]] = 1'b1;
    end
  end

  assign earned = grant_take && grant_valid && multi && (policy_sel == ctp_pkg::POL_ROTATE);

  a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (thread_active[grant_tid] &&
                     ctp_pkg::is_eligible(thread_status[grant_tid*STW +: STW])));

  a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && multi) |-> (head_ready[grant_tid] && !rob_empty[grant_tid]));

  a_r7_no_older: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && multi && policy_sel != ctp_pkg::POL_ROTATE) |-> !older_exists);

  a_r8_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && ok_thr == '0) |-> (!grant_valid && grant_tid == '0));

  a_r6_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !earned |=> $stable(order_flat));
endmodule

bind commit_thread_pick ctp_checker #(.N(N), .SEQ_W(SEQ_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .policy_sel    (policy_sel),
  .thread_active (thread_active),
  .thread_status (thread_status),
  .rob_empty     (rob_empty),
  .head_ready    (head_ready),
  .head_seq      (head_seq),
  .grant_take    (grant_take),
  .grant_valid   (grant_valid),
  .grant_tid     (grant_tid),
  .order_flat    (order_flat)
);

// File: tb/commit_thread_pick_test.sv
module commit_thread_pick_test;
  localparam int N = 4;
  localparam int SW = 16;
  localparam int TW = $clog2(N);

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] policy_sel = 1;
  logic [N-1:0] thread_active = '1;
  logic [N*3-1:0] thread_status = '0;
  logic [N-1:0] rob_empty = '0;
  logic [N-1:0] head_ready = '1;
  logic [N*SW-1:0] head_seq = '0;
  logic grant_take = 0;
  logic grant_valid;
  logic [TW-1:0] grant_tid;

  int checks = 0;
  int errors = 0;
  int order_m[$];
  bit done = 0;

  always #10 clk = ~clk;

  commit_thread_pick #(.N(N), .SEQ_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .thread_active(thread_active), .thread_status(thread_status),
    .rob_empty(rob_empty), .head_ready(head_ready), .head_seq(head_seq),
    .grant_take(grant_take), .grant_valid(grant_valid), .grant_tid(grant_tid)
  );

  function automatic bit can_commit(int i);
    int st = int'(thread_status[i*3 +: 3]);
    return thread_active[i] && (st <= 2);
  endfunction

  function automatic bit is_cand(int i);
    return can_commit(i) && head_ready[i] && !rob_empty[i];
  endfunction

  task automatic step(input string tag);
    int nact = 0, low = -1, ev = 0, et = 0, pos = -1;
    int bestseq = 0;
    #1;
    for (int i = 0; i < N; i++)
      if (thread_active[i]) begin nact++; if (low < 0) low = i; end
    if (nact == 1) begin
      ev = can_commit(low);
      et = ev ? low : 0;
    end else if (policy_sel == 2'd1) begin
      for (int k = 0; k < order_m.size(); k++)
        if (ev == 0 && is_cand(order_m[k])) begin ev = 1; et = order_m[k]; pos = k; end
    end else begin
      for (int i = 0; i < N; i++)
        if (is_cand(i) && (ev == 0 || int'(head_seq[i*SW +: SW]) < bestseq)) begin
          ev = 1; et = i; bestseq = int'(head_seq[i*SW +: SW]);
        end
    end
    checks++;
    if (grant_valid !== 1'(ev) || int'(grant_tid) != et) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d expected valid=%0d tid=%0d",
               tag, grant_valid, grant_tid, ev, et);
    end
    if (grant_take && ev == 1 && policy_sel == 2'd1 && nact != 1) begin
      order_m.delete(pos);
      order_m.push_back(et);
    end
    @(negedge clk);
  endtask

  task automatic set_all(input int pol, input int act, input int rdy, input int emp, input int tk);
    policy_sel = 2'(pol); thread_active = N'(act); head_ready = N'(rdy);
    rob_empty = N'(emp); grant_take = 1'(tk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) order_m.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6 reset order: thread 0 at front
    set_all(1, 4'hF, 4'hF, 0, 0);
    step("R6 reset order");
    // R4/R5 rotation on take
    grant_take = 1;
    repeat (5) step("R5 rotate on take");
    // R4 scan skips non-candidates
    head_ready = 4'b1011;
    repeat (3) step("R4 scan front to back");
    // R10 no take keeps order
    grant_take = 0; head_ready = 4'hF;
    repeat (2) step("R10 hold without take");
    policy_sel = 2; grant_take = 1;
    head_seq = {16'd5, 16'd9, 16'd3, 16'd7};
    repeat (2) step("R7 age order");
    policy_sel = 1; grant_take = 0;
    step("R10 order unchanged after age policy");
    // R2 status exclusion
    thread_status = {3'd4, 3'd3, 3'd2, 3'd1};
    grant_take = 1;
    repeat (3) step("R2 status filter");
    thread_status = '0;
    // R3 empty flag
    rob_empty = 4'b0110; step("R3 empty excluded");
    rob_empty = 0;
    // R7 tie -> lower index; R1 aggressive and code 3
    head_seq = {16'd2, 16'd4, 16'd2, 16'd4};
    policy_sel = 0; step("R1 aggressive tie R7");
    policy_sel = 3; step("R1 code3 age");
    // R8 none
    head_ready = 0; policy_sel = 1; step("R8 no candidate rr");
    policy_sel = 2; step("R8 no candidate age");
    // R9 single active
    thread_active = 4'b0100; policy_sel = 1; head_ready = 0; rob_empty = 4'hF;
    step("R9 single ready ignored");
    thread_status = {3'd0, 3'd3, 3'd0, 3'd0}; step("R9 single ineligible");
    thread_status = 0; thread_active = 4'hF; head_ready = 4'hF; rob_empty = 0;
    grant_take = 0;
    step("R9 no rotation in single mode");
    // mixed random patterns
    for (int n = 0; n < 3000; n++) begin
      policy_sel = 2'($urandom_range(0, 3));
      thread_active = N'($urandom_range(0, 15));
      for (int i = 0; i < N; i++) begin
        thread_status[i*3 +: 3] = ($urandom_range(0, 3) != 0) ? 3'($urandom_range(0, 2))
                                                               : 3'($urandom_range(3, 7));
        head_seq[i*SW +: SW] = SW'($urandom_range(0, 7));
      end
      head_ready = N'($urandom_range(0, 15));
      rob_empty = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
      grant_take = 1'($urandom_range(0, 1));
      step("R1 R4 R5 R7 mixed");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule